// File: doc/BRIEF.md
# Banked Scratch RAM with Bit Window and Stack

This block is a 128-byte on-chip data store shared by four access paths: a plain byte port, a register port that reaches one of four banks of eight working registers, a bit port that reads, sets or clears single bits inside a sixteen-byte window, and a stack engine with push and pop strobes and its own stack pointer. All four paths end on one array. The array takes at most one access per clock.

When several paths request in the same cycle, a fixed priority picks the winner. Every losing request sees its stall output high in that same cycle. A stalled request is simply not performed, and the requester must hold it until the stall clears. Read results are registered: each path's read output updates one clock after that path is granted, and it holds its value until the path is granted again.

Top module: `iram_bank_file`

## Requirements
- R1: The byte port writes `byte_wdata_i` at `byte_addr_i` on the granted clock edge. After every granted byte access, `byte_rdata_o` shows the contents the byte had before that access.
- R2: The register port addresses byte `bank_sel_i*8 + reg_idx_i`, where `bank_sel_i[1]` is the high select bit. It writes on `reg_we_i`, and `reg_rdata_o` shows the prior contents one clock after the grant.
- R3: Every byte in 00h–1Fh can be reached through the byte port whatever bank the register port uses. Bytes written through the byte port can be read back through the register port.
- R4: Bit address b selects byte 20h + b[6:3] and bit position b[2:0]. `bit_op_i` encodes 00 = read, 01 = set, 10 = clear and 11 = read. `bit_rdata_o` shows the bit's value before the operation, one clock after the grant.
- R5: A bit set or clear changes only the addressed bit. The other seven bits of that byte keep their values.
- R6: Bit operations never change a byte outside 20h–2Fh.
- R7: After reset, `sp_o` is 07h and all read outputs, stalls and array bytes are zero. The first push therefore stores at 08h.
- R8: A granted push adds one to the stack pointer, then writes `push_data_i` at the new pointer. The array address is the pointer's low seven bits.
- R9: A granted pop puts the byte at the current pointer on `pop_data_o` one clock later, and subtracts one from the pointer.
- R10: Priority is push, then pop, then register, then bit, then byte. Each losing requester's stall output is high in the same cycle as its request.
- R11: A stalled request changes neither the array, nor the stack pointer, nor its own read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_req_i | input | 1 | Byte port request |
| byte_we_i | input | 1 | Byte port write enable |
| byte_addr_i | input | 7 | Byte address 00h–7Fh |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Registered byte read data |
| byte_stall_o | output | 1 | Byte request lost arbitration |
| reg_req_i | input | 1 | Register port request |
| reg_we_i | input | 1 | Register port write enable |
| reg_idx_i | input | 3 | Register index within bank |
| bank_sel_i | input | 2 | Bank select, bit 1 high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered register read data |
| reg_stall_o | output | 1 | Register request lost arbitration |
| bit_req_i | input | 1 | Bit port request |
| bit_op_i | input | 2 | 00 read, 01 set, 10 clear, 11 read |
| bit_addr_i | input | 7 | Bit address 00h–7Fh |
| bit_rdata_o | output | 1 | Registered prior bit value |
| bit_stall_o | output | 1 | Bit request lost arbitration |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 8 | Registered popped byte |
| pop_stall_o | output | 1 | Pop lost to a push in the same cycle |
| sp_o | output | 8 | Current stack pointer |

## Verification
Every path shares one array, so a corrupted byte does not show until some port reads that address. A bad bank mapping therefore shows as wrong data when the byte port reads the same address, one clock after that read is granted. A wrong bit mask shows in the same way, as wrong neighbouring bits the first time that byte is read whole. A stack pointer error shows on `sp_o` on the clock after the push or pop, and an arbitration error shows on the stall outputs in the same cycle as the request. A wrongly performed stalled write stays hidden until its target is read back, which is why the bench reads back every target after each contention case.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int unsigned NREQ   = 5;
  // grant index = priority rank, lowest wins
  localparam int unsigned G_PUSH = 0;
  localparam int unsigned G_POP  = 1;
  localparam int unsigned G_REG  = 2;
  localparam int unsigned G_BIT  = 3;
  localparam int unsigned G_BYTE = 4;

  typedef enum logic [1:0] {
    BOP_READ = 2'b00,
    BOP_SET  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_PEEK = 2'b11
  } bit_op_e;
endpackage

// File: rtl/iram_arbiter.sv
module iram_arbiter #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic [N-1:0] stall_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign stall_o = req_i & ~gnt_o;

  // R10
  one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> ($onehot(gnt_o) && ((gnt_o & req_i) == gnt_o)));
endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
  parameter int unsigned SP_W   = 8,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned SP_RST = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_gnt_i,
  input  logic              pop_gnt_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [ADDR_W-1:0] pop_addr_o
);
  logic [SP_W-1:0] sp_q, sp_inc;

  assign sp_inc      = sp_q + SP_W'(1);
  assign push_addr_o = sp_inc[ADDR_W-1:0];  // pre-increment
  assign pop_addr_o  = sp_q[ADDR_W-1:0];    // read then decrement
  assign sp_o        = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sp_q <= SP_W'(SP_RST);
    else if (push_gnt_i) sp_q <= sp_inc;
    else if (pop_gnt_i)  sp_q <= sp_q - SP_W'(1);
  end

  // R8
  sp_push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_gnt_i |=> sp_o == $past(sp_o) + SP_W'(1));
  // R9
  sp_pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_gnt_i && !push_gnt_i) |=> sp_o == $past(sp_o) - SP_W'(1));
  // R11
  sp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_gnt_i && !pop_gnt_i) |=> $stable(sp_o));
endmodule

// File: rtl/iram_port_mux.sv
module iram_port_mux
  import iram_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned BIT_BASE = 32
) (
  input  logic [NREQ-1:0]   gnt_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  bit_op_e           bit_op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DW-1:0]     byte_wdata_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DW-1:0]     wdata_o,
  output logic              bit_val_o
);
  localparam int unsigned BPOS_W = $clog2(DW);

  logic [ADDR_W-1:0] bit_byte;
  logic [DW-1:0]     bit_mask;
  logic [ADDR_W-1:0] reg_addr;

  assign bit_byte  = ADDR_W'(BIT_BASE) + ADDR_W'(bit_addr_i[ADDR_W-1:BPOS_W]);
  assign bit_mask  = DW'(1) << bit_addr_i[BPOS_W-1:0];
  assign bit_val_o = rd_data_i[bit_addr_i[BPOS_W-1:0]];
  assign reg_addr  = ADDR_W'({bank_sel_i, reg_idx_i});

  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    wdata_o = '0;
    if (gnt_i[G_PUSH]) begin
      addr_o  = push_addr_i;
      we_o    = 1'b1;
      wdata_o = push_data_i;
    end else if (gnt_i[G_POP]) begin
      addr_o = pop_addr_i;
    end else if (gnt_i[G_REG]) begin
      addr_o  = reg_addr;
      we_o    = reg_we_i;
      wdata_o = reg_wdata_i;
    end else if (gnt_i[G_BIT]) begin
      addr_o = bit_byte;
      unique case (bit_op_i)
        BOP_SET: begin we_o = 1'b1; wdata_o = rd_data_i | bit_mask;  end
        BOP_CLR: begin we_o = 1'b1; wdata_o = rd_data_i & ~bit_mask; end
        default: ;
      endcase
    end else if (gnt_i[G_BYTE]) begin
      addr_o  = byte_addr_i;
      we_o    = byte_we_i;
      wdata_o = byte_wdata_i;
    end
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DW     = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // R1
  store_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/iram_bank_file.sv
module iram_bank_file
  import iram_pkg::*;
#(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned DW       = 8,
  parameter int unsigned NREG     = 8,
  parameter int unsigned NBANK    = 4,
  parameter int unsigned BIT_BASE = 32,
  parameter int unsigned SP_W     = 8,
  parameter int unsigned SP_RST   = 7,
  localparam int unsigned ADDR_W  = $clog2(DEPTH),
  localparam int unsigned IDX_W   = $clog2(NREG),
  localparam int unsigned BANK_W  = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_req_i,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DW-1:0]     byte_wdata_i,
  output logic [DW-1:0]     byte_rdata_o,
  output logic              byte_stall_o,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              reg_stall_o,
  input  logic              bit_req_i,
  input  logic [1:0]        bit_op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic              bit_rdata_o,
  output logic              bit_stall_o,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  output logic [DW-1:0]     pop_data_o,
  output logic              pop_stall_o,
  output logic [SP_W-1:0]   sp_o
);
  logic [NREQ-1:0]   req, gnt, stall;
  logic [ADDR_W-1:0] push_addr, pop_addr, acc_addr;
  logic              acc_we, bit_val;
  logic [DW-1:0]     acc_wdata, rd_data;

  always_comb begin
    req         = '0;
    req[G_PUSH] = push_i;
    req[G_POP]  = pop_i;
    req[G_REG]  = reg_req_i;
    req[G_BIT]  = bit_req_i;
    req[G_BYTE] = byte_req_i;
  end

  iram_arbiter #(.N(NREQ)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .gnt_o(gnt), .stall_o(stall)
  );

  assign pop_stall_o  = stall[G_POP];
  assign reg_stall_o  = stall[G_REG];
  assign bit_stall_o  = stall[G_BIT];
  assign byte_stall_o = stall[G_BYTE];

  iram_sp #(.SP_W(SP_W), .ADDR_W(ADDR_W), .SP_RST(SP_RST)) u_sp (
    .clk_i, .rst_ni,
    .push_gnt_i(gnt[G_PUSH]), .pop_gnt_i(gnt[G_POP]),
    .sp_o, .push_addr_o(push_addr), .pop_addr_o(pop_addr)
  );

  iram_port_mux #(
    .DW(DW), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
  ) u_mux (
    .gnt_i(gnt), .push_addr_i(push_addr), .pop_addr_i(pop_addr),
    .push_data_i, .reg_we_i, .reg_idx_i, .bank_sel_i, .reg_wdata_i,
    .bit_op_i(bit_op_e'(bit_op_i)), .bit_addr_i,
    .byte_we_i, .byte_addr_i, .byte_wdata_i,
    .rd_data_i(rd_data), .addr_o(acc_addr), .we_o(acc_we),
    .wdata_o(acc_wdata), .bit_val_o(bit_val)
  );

  iram_store #(.DEPTH(DEPTH), .DW(DW), .ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni, .addr_i(acc_addr), .we_i(acc_we),
    .wdata_i(acc_wdata), .rd_data_o(rd_data)
  );

  // per-path registered returns, each held until its next grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_rdata_o <= '0;
      reg_rdata_o  <= '0;
      bit_rdata_o  <= 1'b0;
      pop_data_o   <= '0;
    end else begin
      if (gnt[G_BYTE]) byte_rdata_o <= rd_data;
      if (gnt[G_REG])  reg_rdata_o  <= rd_data;
      if (gnt[G_BIT])  bit_rdata_o  <= bit_val;
      if (gnt[G_POP])  pop_data_o   <= rd_data;
    end
  end

  // R11
  byte_stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stall_o |=> $stable(byte_rdata_o));
  // R10
  stack_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && (reg_req_i || bit_req_i || byte_req_i)) |->
      (reg_stall_o == reg_req_i && bit_stall_o == bit_req_i && byte_stall_o == byte_req_i));
endmodule

// File: tb/iram_bank_file_bench.sv
module iram_bank_file_bench;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_req_i = 0, byte_we_i = 0;
  logic [6:0] byte_addr_i = 0;
  logic [7:0] byte_wdata_i = 0;
  logic [7:0] byte_rdata_o;
  logic       byte_stall_o;
  logic       reg_req_i = 0, reg_we_i = 0;
  logic [2:0] reg_idx_i = 0;
  logic [1:0] bank_sel_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       reg_stall_o;
  logic       bit_req_i = 0;
  logic [1:0] bit_op_i = 0;
  logic [6:0] bit_addr_i = 0;
  logic       bit_rdata_o, bit_stall_o;
  logic       push_i = 0, pop_i = 0;
  logic [7:0] push_data_i = 0;
  logic [7:0] pop_data_o;
  logic       pop_stall_o;
  logic [7:0] sp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  iram_bank_file u_iram_bank_file (.*);

  // vector: kind, addr (reg kinds: {bank,idx}), data, expected, requirement number
  localparam logic [2:0] K_BWR = 0, K_BRD = 1, K_RWR = 2, K_RRD = 3,
                         K_BSET = 4, K_BCLR = 5, K_BITRD = 6;
  localparam int NV = 22;
  localparam logic [29:0] VEC [NV] = '{
    {K_RWR,  7'h00, 8'h11, 8'h00, 4'd2},
    {K_RWR,  7'h1F, 8'h22, 8'h00, 4'd2},
    {K_BRD,  7'h00, 8'h00, 8'h11, 4'd2},   // R2 bank0 R0
    {K_BRD,  7'h1F, 8'h00, 8'h22, 4'd2},   // R2 bank3 R7
    {K_RWR,  7'h15, 8'h33, 8'h00, 4'd2},
    {K_BRD,  7'h15, 8'h00, 8'h33, 4'd2},   // R2 bank2 R5
    {K_BWR,  7'h0E, 8'h44, 8'h00, 4'd3},
    {K_RRD,  7'h0E, 8'h00, 8'h44, 4'd3},   // R3 bank1 R6 via byte write
    {K_BWR,  7'h1A, 8'h66, 8'h00, 4'd3},
    {K_RRD,  7'h1A, 8'h00, 8'h66, 4'd3},   // R3 bank3 R2
    {K_BWR,  7'h25, 8'h0F, 8'h00, 4'd1},
    {K_BSET, 7'h2C, 8'h00, 8'h00, 4'd4},
    {K_BRD,  7'h25, 8'h00, 8'h1F, 4'd5},   // R5 set bit4 of 25h
    {K_BCLR, 7'h28, 8'h00, 8'h00, 4'd4},
    {K_BRD,  7'h25, 8'h00, 8'h1E, 4'd5},   // R5 clear bit0 of 25h
    {K_BITRD,7'h29, 8'h00, 8'h01, 4'd4},   // R4
    {K_BITRD,7'h28, 8'h00, 8'h00, 4'd4},   // R4
    {K_BWR,  7'h7F, 8'h5A, 8'h00, 4'd1},
    {K_BRD,  7'h7F, 8'h00, 8'h5A, 4'd1},   // R1 top byte
    {K_BSET, 7'h7F, 8'h00, 8'h00, 4'd4},
    {K_BRD,  7'h2F, 8'h00, 8'h80, 4'd4},   // R4 last bit lands in 2Fh bit7
    {K_BRD,  7'h30, 8'h00, 8'h00, 4'd6}    // R6 byte above window untouched
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic clear_in();
    byte_req_i = 0; byte_we_i = 0; reg_req_i = 0; reg_we_i = 0;
    bit_req_i = 0; push_i = 0; pop_i = 0;
  endtask

  task automatic set_op(input logic [2:0] k, input logic [6:0] a, input logic [7:0] d);
    case (k)
      K_BWR, K_BRD: begin
        byte_req_i = 1; byte_we_i = (k == K_BWR); byte_addr_i = a; byte_wdata_i = d;
      end
      K_RWR, K_RRD: begin
        reg_req_i = 1; reg_we_i = (k == K_RWR);
        bank_sel_i = a[4:3]; reg_idx_i = a[2:0]; reg_wdata_i = d;
      end
      default: begin
        bit_req_i = 1; bit_addr_i = a;
        bit_op_i = (k == K_BSET) ? 2'b01 : (k == K_BCLR) ? 2'b10 : 2'b00;
      end
    endcase
  endtask

  // one access, result sampled on the following falling edge
  task automatic run_op(input logic [2:0] k, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk_i); clear_in(); set_op(k, a, d);
    @(negedge clk_i); clear_in();
  endtask

  task automatic rd_byte(input string req, input logic [6:0] a, input logic [7:0] exp);
    run_op(K_BRD, a, 8'h00);
    chk(req, byte_rdata_o, exp);
  endtask

  task automatic do_push(input logic [7:0] d);
    @(negedge clk_i); clear_in(); push_i = 1; push_data_i = d;
    @(negedge clk_i); clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 reset state
    chk("R7", sp_o, 8'h07);
    chk("R7", byte_rdata_o | reg_rdata_o | pop_data_o, 8'h00);
    chk("R7", {4'b0, bit_rdata_o, reg_stall_o, bit_stall_o, byte_stall_o}, 8'h00);
    rd_byte("R7", 7'h44, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      run_op(v[29:27], v[26:20], v[19:12]);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      case (v[29:27])
        K_BRD:   chk(tag, byte_rdata_o, v[11:4]);
        K_RRD:   chk(tag, reg_rdata_o, v[11:4]);
        K_BITRD: chk(tag, {7'b0, bit_rdata_o}, v[11:4]);
        default: ;
      endcase
    end
    rd_byte("R6", 7'h24, 8'h00);

    // R7 R8 stack: first push at 08h
    do_push(8'hAA);
    chk("R7", sp_o, 8'h08);
    rd_byte("R8", 7'h08, 8'hAA);
    do_push(8'hBB);
    chk("R8", sp_o, 8'h09);
    // R9 pop reads then decrements
    @(negedge clk_i); pop_i = 1;
    @(negedge clk_i); clear_in();
    chk("R9", pop_data_o, 8'hBB);
    chk("R9", sp_o, 8'h08);

    // R10 push beats register, bit and byte
    @(negedge clk_i);
    push_i = 1; push_data_i = 8'hC3;
    set_op(K_RWR, 7'h01, 8'h99); set_op(K_BSET, 7'h30, 8'h00); set_op(K_BWR, 7'h40, 8'h77);
    #(CLK_PERIOD / 4);
    chk("R10", {5'b0, reg_stall_o, bit_stall_o, byte_stall_o}, 8'h07);
    @(negedge clk_i); clear_in();
    chk("R8", sp_o, 8'h09);
    rd_byte("R8", 7'h09, 8'hC3);
    rd_byte("R11", 7'h01, 8'h00);
    rd_byte("R11", 7'h26, 8'h00);
    rd_byte("R11", 7'h40, 8'h00);

    // R10 register beats bit and byte
    @(negedge clk_i);
    set_op(K_RWR, 7'h02, 8'h12); set_op(K_BSET, 7'h31, 8'h00); set_op(K_BWR, 7'h41, 8'h34);
    #(CLK_PERIOD / 4);
    chk("R10", {5'b0, reg_stall_o, bit_stall_o, byte_stall_o}, 8'h03);
    @(negedge clk_i); clear_in();
    rd_byte("R10", 7'h02, 8'h12);
    rd_byte("R11", 7'h26, 8'h00);
    rd_byte("R11", 7'h41, 8'h00);

    // R10 bit beats byte
    @(negedge clk_i);
    set_op(K_BSET, 7'h31, 8'h00); set_op(K_BWR, 7'h41, 8'h34);
    #(CLK_PERIOD / 4);
    chk("R10", {6'b0, bit_stall_o, byte_stall_o}, 8'h01);
    @(negedge clk_i); clear_in();
    rd_byte("R10", 7'h26, 8'h02);
    rd_byte("R11", 7'h41, 8'h00);

    // R10 push beats pop
    @(negedge clk_i);
    push_i = 1; push_data_i = 8'hDD; pop_i = 1;
    #(CLK_PERIOD / 4);
    chk("R10", {7'b0, pop_stall_o}, 8'h01);
    @(negedge clk_i); clear_in();
    chk("R11", pop_data_o, 8'hBB);
    chk("R10", sp_o, 8'h0A);
    @(negedge clk_i); pop_i = 1;
    @(negedge clk_i); clear_in();
    chk("R9", pop_data_o, 8'hDD);
    chk("R9", sp_o, 8'h09);

    // R4 prior value returned on set/clear, opcode 11 reads only
    run_op(K_BSET, 7'h31, 8'h00);
    chk("R4", {7'b0, bit_rdata_o}, 8'h01);
    rd_byte("R5", 7'h26, 8'h02);
    run_op(K_BCLR, 7'h31, 8'h00);
    chk("R4", {7'b0, bit_rdata_o}, 8'h01);
    run_op(K_BITRD, 7'h31, 8'h00);
    chk("R4", {7'b0, bit_rdata_o}, 8'h00);
    @(negedge clk_i); bit_req_i = 1; bit_op_i = 2'b11; bit_addr_i = 7'h2C;
    @(negedge clk_i); clear_in();
    chk("R4", {7'b0, bit_rdata_o}, 8'h01);
    rd_byte("R4", 7'h25, 8'h1E);

    done = 1;
    report();
  end
endmodule